// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Tagged Receive Queue

This block receives asynchronous serial characters on a single line. A one-cycle enable pulse marks each tick of a clock running at sixteen times the bit rate. On every tick the receiver samples the line. It checks the start bit at its middle and then takes each data bit at its centre, least significant bit first. A character carries 5 to 8 data bits, an optional parity or address bit, and one stop bit. When the character is complete, the data and three flags go into a three-entry queue. The flags mark a line break, a missing stop bit, and a parity error or address bit.

One spare holding slot sits in front of the queue. It keeps a character that finished while the queue was full. If another character finishes while that slot is still taken, the held character is lost and a sticky overrun flag is set. A status byte combines four items: the head entry's flags, the overrun flag, two transmitter flags passed through from outside, and the queue's full and non-empty states. A pop strobe takes the head entry off the queue.

The controlling state machine has six states, named here with the transitions between them:
- IDLE goes to START on a tick that samples the line low.
- START goes to DATA if the line is still low on the 8th sample. Otherwise it goes back to IDLE.
- DATA stays until the last data bit has been sampled. It then goes to PAR when a parity or address bit is configured, and to STOP when none is.
- PAR goes to STOP after sampling its bit.
- STOP writes the character. It then goes to BRK when the character is a break and to IDLE otherwise.
- BRK goes to IDLE after 8 consecutive ticks that sample the line high.

Top module: `sio_rx_core`

## Requirements
- R1: After reset, `status` is 8'h00 when both transmitter inputs are low.
- R2: A low sample in idle starts a character only if the 8th tick-sample, counted from that first low sample, is also low. Otherwise nothing is written and the receiver returns to idle.
- R3: Data bits are sampled 16 ticks apart, least significant bit first. `char_len` selects 5 + `char_len` data bits, and `rx_data` bits above the configured length read 0.
- R4: `par_mode`=01 is checked parity. With `par_sel`=0 the parity is even: PE (status bit 5) is set when the XOR of the data bits and the parity bit is 1. With `par_sel`=1 the parity is odd and PE is set when that XOR is 0. `par_mode`=10 forces the parity bit: PE is set when the received bit differs from `par_sel`. `par_mode`=00 means there is no parity bit and PE is 0.
- R5: With `par_mode`=11 (multidrop), the extra bit is received in the parity position and PE holds its value.
- R6: The queue holds 3 entries. FFULL (status bit 1) is 1 while 3 entries are held. RxRDY (status bit 0) is 1 while at least one entry is held. A pulse on `rd_pop` removes the head entry, and a held character moves into the queue once there is room.
- R7: A character is a break when its data bits, its parity bit (if one is configured) and its stop sample are all zero. A break writes exactly one entry, with RB (bit 7)=1, FE (bit 6)=1 and data 0. No further entry is written until the line has been sampled high on 8 consecutive ticks.
- R8: The stop bit is sampled 16 ticks after the last data or parity sample. A low sample sets FE for that character.
- R9: A character that completes while the queue is full and the holding slot is taken replaces the held character, which is lost. It also sets OE (bit 4). OE stays 1 until a `clr_err` pulse.
- R10: Status bit 3 follows `tx_empty_in` and bit 2 follows `tx_ready_in`.
- R11: RB, FE and PE belong to the head entry, and they read 0 while RxRDY is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 00 none, 01 checked, 10 forced, 11 multidrop |
| par_sel | input | 1 | Odd parity / forced parity value |
| rd_pop | input | 1 | Removes the head entry |
| clr_err | input | 1 | Clears OE |
| tx_empty_in | input | 1 | Passed to status bit 3 |
| tx_ready_in | input | 1 | Passed to status bit 2 |
| rx_data | output | 8 | Head entry data |
| status | output | 8 | {RB,FE,PE,OE,TxEMP,TxRDY,FFULL,RxRDY} |

## Verification
A character is written two clock cycles after the tick that samples the middle of its stop bit. One cycle is the state machine's output register and one is the queue write. A pop or an error clear shows on `status` one cycle after the strobe. The bench holds the line idle for at least two bit times after each stop bit before it samples, and it samples one full cycle after each strobe, always on the falling clock edge. Configurations are swept over every character length, every parity mode and several data words, and the expected data and flags are computed in the bench from the bits it sent.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
    } rx_state_e;

    localparam logic [1:0] PM_NONE  = 2'b00;
    localparam logic [1:0] PM_CHECK = 2'b01;
    localparam logic [1:0] PM_FORCE = 2'b10;
    localparam logic [1:0] PM_MULTI = 2'b11;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;
endpackage

// File: rtl/sio_rx_fsm.sv
module sio_rx_fsm
    import sio_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic [1:0] par_mode,
    input  logic       par_sel,
    output logic       char_valid,
    output rx_entry_t  char_word
);
    localparam int CW     = $clog2(OSR);
    localparam int MID    = OSR / 2 - 2;
    localparam int LAST   = OSR - 1;
    localparam int BRK_HI = OSR / 2;

    rx_state_e      state, state_n;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  hicnt;
    logic [2:0]     bidx;
    logic [7:0]     shreg;
    logic           pbit;
    logic [2:0]     last_bit;
    logic           is_brk;
    logic           pe_calc;

    assign last_bit = {1'b1, char_len};
    assign is_brk   = !rxd && (shreg == 8'h00) && ((par_mode == PM_NONE) || !pbit);

    always_comb begin
        unique case (par_mode)
            PM_NONE:  pe_calc = 1'b0;
            PM_CHECK: pe_calc = (^shreg) ^ pbit ^ par_sel;
            PM_FORCE: pe_calc = pbit ^ par_sel;
            default:  pe_calc = pbit;
        endcase
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (tick && !rxd) state_n = ST_START;
            ST_START: if (tick && cnt == CW'(MID)) state_n = rxd ? ST_IDLE : ST_DATA;
            ST_DATA:  if (tick && cnt == CW'(LAST) && bidx == last_bit)
                          state_n = (par_mode == PM_NONE) ? ST_STOP : ST_PAR;
            ST_PAR:   if (tick && cnt == CW'(LAST)) state_n = ST_STOP;
            ST_STOP:  if (tick && cnt == CW'(LAST)) state_n = is_brk ? ST_BRK : ST_IDLE;
            ST_BRK:   if (tick && rxd && hicnt == CW'(BRK_HI - 1)) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            hicnt      <= '0;
            bidx       <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            char_valid <= 1'b0;
            char_word  <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        cnt   <= '0;
                        bidx  <= '0;
                        shreg <= '0;
                        pbit  <= 1'b0;
                    end
                    ST_START: cnt <= (cnt == CW'(MID)) ? '0 : cnt + 1'b1;
                    ST_DATA: begin
                        if (cnt == CW'(LAST)) begin
                            cnt         <= '0;
                            shreg[bidx] <= rxd;
                            bidx        <= bidx + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_PAR: begin
                        if (cnt == CW'(LAST)) begin
                            cnt  <= '0;
                            pbit <= rxd;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_STOP: begin
                        if (cnt == CW'(LAST)) begin
                            cnt        <= '0;
                            hicnt      <= '0;
                            char_valid <= 1'b1;
                            char_word  <= '{brk: is_brk, fe: !rxd, pe: pe_calc, data: shreg};
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_BRK: hicnt <= rxd ? hicnt + 1'b1 : '0;
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // R2: a start that reads high at its 8th sample is dropped
    a_r2_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && cnt == CW'(MID) && rxd) |=> state == ST_IDLE);

    // R7: nothing completes while waiting for the line to recover
    a_r7_brk_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRK && $past(state) == ST_BRK) |-> !char_valid);
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full,
    output logic         overrun
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CTW = $clog2(DEPTH + 1);

    logic [W-1:0]   mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CTW-1:0] cnt;
    logic           hold_v;
    logic [W-1:0]   hold_w;
    logic           do_pop, push_hold, push_new, push;
    logic [W-1:0]   push_word;

    assign full      = (cnt == CTW'(DEPTH));
    assign not_empty = (cnt != '0);
    assign head      = mem[rp];
    assign do_pop    = pop && not_empty;
    assign push_hold = hold_v && !full;
    assign push_new  = in_valid && !hold_v && !full;
    assign push      = push_hold || push_new;
    assign push_word = push_hold ? hold_w : in_word;
    assign overrun   = in_valid && hold_v && full;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            hold_v <= 1'b0;
            hold_w <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_word;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            unique case ({push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (in_valid && (hold_v || full)) begin
                hold_v <= 1'b1;
                hold_w <= in_word;
            end else if (push_hold) begin
                hold_v <= 1'b0;
            end
        end
    end

    // R6: the queue is never written beyond its depth
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> cnt < CTW'(DEPTH));
endmodule

// File: rtl/sio_rx_core.sv
module sio_rx_core
    import sio_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic [1:0] par_mode,
    input  logic       par_sel,
    input  logic       rd_pop,
    input  logic       clr_err,
    input  logic       tx_empty_in,
    input  logic       tx_ready_in,
    output logic [7:0] rx_data,
    output logic [7:0] status
);
    localparam int EW = $bits(rx_entry_t);

    logic      char_valid;
    rx_entry_t char_word;
    rx_entry_t head;
    logic      not_empty, full, overrun;
    logic      oe;

    sio_rx_fsm #(.OSR(OSR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .char_len(char_len), .par_mode(par_mode), .par_sel(par_sel),
        .char_valid(char_valid), .char_word(char_word)
    );

    sio_rx_fifo #(.DEPTH(DEPTH), .W(EW)) fifo_i (
        .clk(clk), .rst_n(rst_n), .in_valid(char_valid), .in_word(char_word),
        .pop(rd_pop), .head(head), .not_empty(not_empty), .full(full),
        .overrun(overrun)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       oe <= 1'b0;
        else if (overrun) oe <= 1'b1;
        else if (clr_err) oe <= 1'b0;
    end

    assign rx_data = head.data;
    assign status  = {head.brk & not_empty, head.fe & not_empty, head.pe & not_empty,
                      oe, tx_empty_in, tx_ready_in, full, not_empty};

    // R9: overrun flag holds until cleared
    a_r9_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !clr_err) |=> oe);

    // R6: a full queue is also a non-empty one
    a_r6_full_ready: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);
endmodule

// File: tb/sio_rx_core_tb.sv
module sio_rx_core_tb_top;
    localparam int CLK_P = 10;
    localparam int BT    = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic [1:0] par_mode = 2'b00;
    logic       par_sel = 1'b0;
    logic       rd_pop = 1'b0;
    logic       clr_err = 1'b0;
    logic       tx_empty_in = 1'b0;
    logic       tx_ready_in = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sio_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .char_len(char_len), .par_mode(par_mode), .par_sel(par_sel),
        .rd_pop(rd_pop), .clr_err(clr_err), .tx_empty_in(tx_empty_in),
        .tx_ready_in(tx_ready_in), .rx_data(rx_data), .status(status)
    );

    always #(CLK_P / 2) clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic lvl, input int n);
        rxd = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit has_par,
                        input bit pb, input int stop_low);
        hold_line(1'b0, BT);
        for (int i = 0; i < nb; i++) hold_line(d[i], BT);
        if (has_par) hold_line(pb, BT);
        if (stop_low > 0) hold_line(1'b0, stop_low);
        hold_line(1'b1, BT - stop_low);
        hold_line(1'b1, 2 * BT);
    endtask

    task automatic pop_one();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", {8'h0, status}, 16'h0000);

        // R10 pass-through
        tx_empty_in = 1'b1; tx_ready_in = 1'b0; @(negedge clk);
        check("R10 txemp bit", {14'h0, status[3:2]}, 16'h0002);
        tx_empty_in = 1'b0; tx_ready_in = 1'b1; @(negedge clk);
        check("R10 txrdy bit", {14'h0, status[3:2]}, 16'h0001);
        tx_ready_in = 1'b0;

        // R2 false start
        hold_line(1'b0, 8);
        hold_line(1'b1, 4 * BT);
        check("R2 false start ignored", {15'h0, status[0]}, 16'h0000);
        check("R11 flags zero when empty", {13'h0, status[7:5]}, 16'h0000);

        // R3 R4 R5 sweep: lengths x modes x data words
        for (int len = 0; len < 4; len++) begin
            for (int m = 0; m < 7; m++) begin
                for (int k = 0; k < 3; k++) begin
                    int          nb;
                    logic [7:0]  mask, d;
                    bit          pb, exp_pe, has_par;
                    nb   = 5 + len;
                    mask = 8'((1 << nb) - 1);
                    d    = (8'(k * 8'h5B + m * 8'h11 + len) | 8'h01) & mask;
                    char_len = 2'(len);
                    has_par  = (m != 0);
                    unique case (m)
                        0: begin par_mode = 2'b00; par_sel = 1'b0; pb = 1'b0; end
                        1: begin par_mode = 2'b01; par_sel = 1'b0; pb = ^d; end
                        2: begin par_mode = 2'b01; par_sel = 1'b1; pb = ~^d; end
                        3: begin par_mode = 2'b10; par_sel = 1'b0; pb = 1'b0; end
                        4: begin par_mode = 2'b10; par_sel = 1'b1; pb = 1'b1; end
                        5: begin par_mode = 2'b11; par_sel = 1'b0; pb = 1'b0; end
                        default: begin par_mode = 2'b11; par_sel = 1'b0; pb = 1'b1; end
                    endcase
                    exp_pe = 1'b0;
                    if (m >= 1 && m <= 4 && k == 1) begin
                        pb = ~pb;
                        exp_pe = 1'b1;
                    end
                    if (m == 6) exp_pe = 1'b1;
                    send(d, nb, has_par, pb, 0);
                    check("R3 R6 rxrdy after char", {15'h0, status[0]}, 16'h0001);
                    if (m == 5 || m == 6)
                        check("R5 multidrop data and flags", {5'h0, status[7:5], rx_data},
                              {5'h0, 2'b00, exp_pe, d});
                    else
                        check("R3 R4 data and flags", {5'h0, status[7:5], rx_data},
                              {5'h0, 2'b00, exp_pe, d});
                    pop_one();
                    check("R6 pop empties", {15'h0, status[0]}, 16'h0001 ^ 16'h0001);
                end
            end
        end

        // R8 framing error
        char_len = 2'd3; par_mode = 2'b00; par_sel = 1'b0;
        send(8'h96, 8, 1'b0, 1'b0, 18);
        check("R8 framing flags", {5'h0, status[7:5], rx_data}, {5'h0, 3'b010, 8'h96});
        pop_one();
        check("R8 single entry", {15'h0, status[0]}, 16'h0000);

        // R9 overrun
        for (int i = 1; i <= 5; i++) send(8'(i * 8'h11), 8, 1'b0, 1'b0, 0);
        check("R6 ffull", {14'h0, status[1:0]}, 16'h0003);
        check("R9 oe set", {15'h0, status[4]}, 16'h0001);
        check("R9 head 1", {8'h0, rx_data}, 16'h0011);
        pop_one(); @(negedge clk);
        check("R6 R9 refill from hold", {14'h0, status[1:0]}, 16'h0003);
        check("R9 head 2", {8'h0, rx_data}, 16'h0022);
        pop_one();
        check("R9 head 3", {8'h0, rx_data}, 16'h0033);
        pop_one();
        check("R9 survivor is last char", {8'h0, rx_data}, 16'h0055);
        pop_one();
        check("R6 drained", {15'h0, status[0]}, 16'h0000);
        check("R9 oe sticky", {15'h0, status[4]}, 16'h0001);
        @(negedge clk) clr_err = 1'b1;
        @(negedge clk) clr_err = 1'b0;
        check("R9 oe cleared", {15'h0, status[4]}, 16'h0000);

        // R7 break
        hold_line(1'b0, 14 * BT);
        check("R7 break entry", {5'h0, status[7:5], rx_data}, {5'h0, 3'b110, 8'h00});
        pop_one();
        hold_line(1'b1, 6);
        hold_line(1'b0, 3 * BT);
        check("R7 blocked after break", {15'h0, status[0]}, 16'h0000);
        hold_line(1'b1, 2 * BT);
        send(8'h5A, 8, 1'b0, 1'b0, 0);
        check("R7 resumes after recovery", {5'h0, status[7:5], rx_data},
              {5'h0, 3'b000, 8'h5A});
        pop_one();
        check("R7 only one new entry", {15'h0, status[0]}, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule